// File: doc/BRIEF.md
# Integer Twin Butterfly Unit

This block is a pipelined integer datapath for the butterfly stages of a discrete cosine transform. Each issued operation takes two signed operands, a signed coefficient and a right-shift amount. It produces two results from the same issue: the sum of the operands times the coefficient, and their difference times the same coefficient. Both products are scaled down by the same arithmetic right shift.

Each result lane ends in an output register that can either be overwritten or accumulated into. A butterfly with two coefficients therefore takes two issues. The first issue overwrites. The second issue has the operand order swapped, a different coefficient and the accumulate flag set. A synchronous clear zeroes both output registers. The unit accepts one operation per cycle, and each result appears a fixed two cycles after its issue.

Top module: `twin_bfly_unit`

## Requirements
- R1: When a result retires with accumulate low and clear low, `out_sum` equals the low 32 bits of ((a + b) * c) arithmetically shifted right by N.
- R2: In the same retire cycle, `out_dif` equals the low 32 bits of ((a − b) * c) arithmetically shifted right by N, taken from the same issue as `out_sum`.
- R3: N is the 5-bit `in_shift` value (0 to 31). The shift is arithmetic, so a negative product stays negative after shifting.
- R4: Operands and the coefficient are signed 32-bit two's complement. The sum, the difference and the product are formed at full precision (65 bits) before the shift. Only the shifted value is cut to 32 bits, and it wraps on overflow.
- R5: With `in_acc` high, each retiring result is added modulo 2^32 to the value currently held in its output register.
- R6: With `in_acc` low, a retiring result replaces the held output value.
- R7: `out_valid` goes high exactly two rising edges after the edge that captured `in_valid` high. Issues on back-to-back cycles retire on back-to-back cycles, in order.
- R8: Both outputs hold their value in any cycle where no result retires and `clr` is low.
- R9: `clr` high zeroes both outputs at the next edge. If a result retires at that same edge, it is written onto a zero base, so the output equals the new result whatever `in_acc` was.
- R10: When a equals b and accumulate is low, `out_dif` is exactly zero.
- R11: While `rst_n` is low, `out_valid` is low and both outputs are zero.
- R12: Issue (a, b, c1, N, acc=0) followed by issue (b, a, c2, N, acc=1) leaves the sum of the two individual shifted results in each output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of both output accumulators |
| in_valid | input | 1 | Issue strobe for one operation |
| in_a | input | 32 | Operand a, signed |
| in_b | input | 32 | Operand b, signed |
| in_coef | input | 32 | Coefficient c, signed |
| in_shift | input | 5 | Right-shift amount N |
| in_acc | input | 1 | 1: accumulate into held outputs, 0: overwrite |
| out_valid | output | 1 | A result pair retired at the last edge |
| out_sum | output | 32 | Sum-lane result register |
| out_dif | output | 32 | Difference-lane result register |

## Verification
Small positive operands with N = 0 show whether the two lanes are swapped and whether the sign of the difference is right. Negative products shifted by 31, and maximum-magnitude operands with N = 0, separate an arithmetic shift from a logical one and a 65-bit intermediate from a narrower one. Equal operands, swapped-order accumulate pairs, idle gaps and clear pulses (alone, and at the same edge as a retire) separate overwrite from accumulate, hold from drift, and clear priority from a lost result. A long run of random back-to-back issues with mixed accumulate flags checks ordering and the two-cycle latency.

// File: rtl/twin_bfly_pkg.sv
package twin_bfly_pkg;

    // Default widths of the datapath.
    localparam int TBU_DATA_W  = 32;
    localparam int TBU_SHIFT_W = 5;

    // Result lanes: one fed by a+b, one by a-b.
    typedef enum logic [0:0] {
        LANE_SUM = 1'b0,
        LANE_DIF = 1'b1
    } lane_kind_e;

    localparam int TBU_NUM_LANES = 2;

endpackage

// File: rtl/twin_bfly_preadd.sv
// Stage 1: register the widened sum and difference plus the control fields.
module twin_bfly_preadd #(
    parameter int DATA_W  = twin_bfly_pkg::TBU_DATA_W,
    parameter int SHIFT_W = twin_bfly_pkg::TBU_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic [DATA_W-1:0]  in_coef,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_acc,
    output logic               st_vld,
    output logic               st_acc,
    output logic [SHIFT_W-1:0] st_shamt,
    output logic [DATA_W-1:0]  st_coef,
    output logic [DATA_W:0]    st_sum,
    output logic [DATA_W:0]    st_dif
);
    localparam int OPW = DATA_W + 1;

    typedef struct packed {
        logic               vld;
        logic               acc;
        logic [SHIFT_W-1:0] shamt;
        logic [DATA_W-1:0]  coef;
        logic [OPW-1:0]     sum;
        logic [OPW-1:0]     dif;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [OPW-1:0] a_x, b_x;

    always_comb begin
        a_x       = {in_a[DATA_W-1], in_a};
        b_x       = {in_b[DATA_W-1], in_b};
        pre_d     = pre_q;
        pre_d.vld = in_valid;
        // Data fields only move when an issue arrives, to keep idle cycles quiet.
        if (in_valid) begin
            pre_d.acc   = in_acc;
            pre_d.shamt = in_shift;
            pre_d.coef  = in_coef;
            pre_d.sum   = a_x + b_x;
            pre_d.dif   = a_x - b_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    assign st_vld   = pre_q.vld;
    assign st_acc   = pre_q.acc;
    assign st_shamt = pre_q.shamt;
    assign st_coef  = pre_q.coef;
    assign st_sum   = pre_q.sum;
    assign st_dif   = pre_q.dif;

    // R10: equal operands give an exactly zero difference term.
    p_equal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a == in_b) |=> (st_dif == '0));

endmodule

// File: rtl/twin_bfly_lane.sv
// Stage 2 of one lane: full-precision multiply, arithmetic shift, truncate, accumulate.
module twin_bfly_lane #(
    parameter int DATA_W  = twin_bfly_pkg::TBU_DATA_W,
    parameter int SHIFT_W = twin_bfly_pkg::TBU_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               vld,
    input  logic               acc,
    input  logic [SHIFT_W-1:0] shamt,
    input  logic [DATA_W-1:0]  coef,
    input  logic [DATA_W:0]    opnd,
    output logic [DATA_W-1:0]  res
);
    localparam int OPW    = DATA_W + 1;
    localparam int PROD_W = OPW + DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] val;
    } lane_t;

    lane_t lane_d, lane_q;

    logic signed [PROD_W-1:0] op_x;
    logic signed [PROD_W-1:0] cf_x;
    logic signed [PROD_W-1:0] prod;
    logic        [DATA_W-1:0] scaled;
    logic        [DATA_W-1:0] base;

    always_comb begin
        op_x   = {{(PROD_W-OPW){opnd[OPW-1]}}, opnd};
        cf_x   = {{(PROD_W-DATA_W){coef[DATA_W-1]}}, coef};
        prod   = op_x * cf_x;
        scaled = DATA_W'(prod >>> shamt);
        // Clear wins over the held value; a retiring result then lands on zero.
        base   = clr ? '0 : lane_q.val;
        lane_d = lane_q;
        if (vld) begin
            lane_d.val = acc ? (base + scaled) : scaled;
        end else if (clr) begin
            lane_d.val = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign res = lane_q.val;

    // R9: a clear with nothing retiring leaves zero.
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !vld) |=> (res == '0));

    // R8: nothing retiring and no clear means the value holds.
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !vld) |=> $stable(res));

endmodule

// File: rtl/twin_bfly_unit.sv
module twin_bfly_unit #(
    parameter int DATA_W  = twin_bfly_pkg::TBU_DATA_W,
    parameter int SHIFT_W = twin_bfly_pkg::TBU_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_a,
    input  logic [DATA_W-1:0]  in_b,
    input  logic [DATA_W-1:0]  in_coef,
    input  logic [SHIFT_W-1:0] in_shift,
    input  logic               in_acc,
    output logic               out_valid,
    output logic [DATA_W-1:0]  out_sum,
    output logic [DATA_W-1:0]  out_dif
);
    import twin_bfly_pkg::*;

    localparam int NUM_LANES = TBU_NUM_LANES;
    localparam int OPW       = DATA_W + 1;

    logic               st_vld;
    logic               st_acc;
    logic [SHIFT_W-1:0] st_shamt;
    logic [DATA_W-1:0]  st_coef;
    logic [OPW-1:0]     st_sum;
    logic [OPW-1:0]     st_dif;
    logic [DATA_W-1:0]  lane_res [NUM_LANES];

    typedef struct packed {
        logic vld;
    } ret_t;

    ret_t ret_d, ret_q;

    twin_bfly_preadd #(
        .DATA_W  (DATA_W),
        .SHIFT_W (SHIFT_W)
    ) u_preadd (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_a     (in_a),
        .in_b     (in_b),
        .in_coef  (in_coef),
        .in_shift (in_shift),
        .in_acc   (in_acc),
        .st_vld   (st_vld),
        .st_acc   (st_acc),
        .st_shamt (st_shamt),
        .st_coef  (st_coef),
        .st_sum   (st_sum),
        .st_dif   (st_dif)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [OPW-1:0] lane_op;
        if (g == int'(LANE_SUM)) begin : g_sum
            assign lane_op = st_sum;
        end else begin : g_dif
            assign lane_op = st_dif;
        end
        twin_bfly_lane #(
            .DATA_W  (DATA_W),
            .SHIFT_W (SHIFT_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .vld   (st_vld),
            .acc   (st_acc),
            .shamt (st_shamt),
            .coef  (st_coef),
            .opnd  (lane_op),
            .res   (lane_res[g])
        );
    end

    always_comb begin
        ret_d     = ret_q;
        ret_d.vld = st_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign out_valid = ret_q.vld;
    assign out_sum   = lane_res[int'(LANE_SUM)];
    assign out_dif   = lane_res[int'(LANE_DIF)];

    // R7: every retire traces back to an issue two edges earlier.
    p_latency_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    // R7: an issue always retires two edges later.
    p_issue_retires_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> st_vld);

    // R11: reset state of the retire flag and both lanes.
    p_reset_state_r11: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_sum == '0 && out_dif == '0));

endmodule

// File: tb/twin_bfly_unit_test.sv
module twin_bfly_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] in_coef = '0;
    logic [4:0]  in_shift = '0;
    logic        in_acc = 1'b0;
    logic        out_valid;
    logic [31:0] out_sum;
    logic [31:0] out_dif;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twin_bfly_unit uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_coef(in_coef), .in_shift(in_shift),
        .in_acc(in_acc), .out_valid(out_valid), .out_sum(out_sum), .out_dif(out_dif)
    );

    typedef struct {
        logic [31:0] r0;
        logic [31:0] r1;
        bit          acc;
        string       tag;
    } item_t;

    item_t exp_q[$];

    function automatic logic [31:0] ref_res(input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] c, input int n, input bit dif);
        logic signed [95:0] sa, sb, sc, p;
        sa = {{64{a[31]}}, a};
        sb = {{64{b[31]}}, b};
        sc = {{64{c[31]}}, c};
        p  = dif ? (sa - sb) * sc : (sa + sb) * sc;
        p  = p >>> n;
        return p[31:0];
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input int n, input bit acc, input string tag);
        item_t it;
        @(negedge clk);
        clr = 1'b0;
        in_valid = 1'b1;
        in_a = a; in_b = b; in_coef = c; in_shift = n[4:0]; in_acc = acc;
        it.r0 = ref_res(a, b, c, n, 1'b0);
        it.r1 = ref_res(a, b, c, n, 1'b1);
        it.acc = acc;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            clr = 1'b0;
        end
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        in_valid = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    // Monitor: sample inputs at the edge, compare just after it settles.
    logic [1:0]  vh = '0;
    logic        clr_s = 1'b0;
    logic [31:0] m0 = '0;
    logic [31:0] m1 = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            vh    <= '0;
            clr_s <= 1'b0;
        end else begin
            vh    <= {vh[0], in_valid};
            clr_s <= clr;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            string tg;
            check("R7", "out_valid", {31'b0, out_valid}, {31'b0, vh[1]});
            if (vh[1]) begin
                item_t it;
                if (exp_q.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R7 retire with empty queue actual=1 expected=0");
                end else begin
                    it = exp_q.pop_front();
                    if (clr_s) begin
                        m0 = '0;
                        m1 = '0;
                    end
                    m0 = it.acc ? m0 + it.r0 : it.r0;
                    m1 = it.acc ? m1 + it.r1 : it.r1;
                    tg = it.tag;
                end
            end else begin
                if (clr_s) begin
                    m0 = '0;
                    m1 = '0;
                    tg = "R9";
                end else begin
                    tg = "R8";
                end
            end
            check(tg, "out_sum", out_sum, m0);
            check(tg, "out_dif", out_dif, m1);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "reset out_valid", {31'b0, out_valid}, 32'd0);
        check("R11", "reset out_sum", out_sum, 32'd0);
        check("R11", "reset out_dif", out_dif, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 R2: small positive, lanes distinct
        issue(32'd3, 32'd5, 32'd7, 0, 1'b0, "R1");
        issue(32'd9, 32'd2, 32'd4, 0, 1'b0, "R2");
        issue(32'd100, 32'd20, 32'd3, 2, 1'b0, "R1");
        // R10: equal operands
        issue(32'd12345, 32'd12345, 32'd77, 0, 1'b0, "R10");
        issue(32'hFFFF_FF00, 32'hFFFF_FF00, 32'h7FFF_FFFF, 5, 1'b0, "R10");
        // R3: negative products and extreme shifts
        issue(32'hFFFF_FFF0, 32'd1, 32'd1000, 31, 1'b0, "R3");
        issue(32'd7, 32'd9, 32'hFFFF_FFFD, 1, 1'b0, "R3");
        issue(32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 31, 1'b0, "R3");
        // R4: full-precision product, wrap of shifted value
        issue(32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1'b0, "R4");
        issue(32'h8000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 16, 1'b0, "R4");
        issue(32'h7FFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 3, 1'b0, "R4");
        idle(3);

        // R12: two-coefficient butterfly via swapped operands
        issue(32'd1500, 32'hFFFF_FC18, 32'd2896, 12, 1'b0, "R12");
        issue(32'hFFFF_FC18, 32'd1500, 32'd1567, 12, 1'b1, "R12");
        idle(3);
        // R5: accumulate chain
        issue(32'd10, 32'd3, 32'd5, 0, 1'b0, "R6");
        issue(32'd1, 32'd2, 32'd3, 0, 1'b1, "R5");
        issue(32'h7FFF_0000, 32'h7FFF_0000, 32'h7FFF, 0, 1'b1, "R5");
        issue(32'd4, 32'd8, 32'hFFFF_FFFF, 1, 1'b1, "R5");
        // R6: overwrite after accumulation
        issue(32'd2, 32'd1, 32'd1, 0, 1'b0, "R6");
        // R8: idle hold
        idle(4);
        // R9: clear alone
        clr_pulse();
        idle(2);
        // R9: clear at the same edge as an accumulate retire
        issue(32'd50, 32'd30, 32'd2, 0, 1'b0, "R6");
        idle(2);
        issue(32'd6, 32'd1, 32'd3, 0, 1'b1, "R9");
        clr_pulse();
        idle(3);

        // R7: long back-to-back random run
        for (int i = 0; i < 300; i++) begin
            issue($urandom, $urandom, $urandom, $urandom_range(0, 31), bit'($urandom_range(0, 1)), "R7");
        end
        idle(5);
        check("R7", "queue drained", exp_q.size(), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule